// File: doc/BRIEF.md
# Infrared serial pulse codec

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side every UART zero bit becomes one short active-high pulse on the optical output, and a one bit leaves the output idle low. On the receive side the transceiver's active-low pulses are synchronised, filtered for glitches and stretched back into UART zero bits that last one full bit period.

Two timing modes are offered. In baud mode the transmit pulse is 3/16 of a bit, timed from the UART's 16x oversampling tick, and the receive glitch filter counts the same ticks. In low-power mode the transmit pulse is three periods of a slow clock made by dividing the system clock by an 8-bit prescaler, and the receive filter counts periods of that slow clock. With the enable low the block is transparent: transmit and receive lines pass straight through. The link is half duplex and turnaround timing is left to software.

Top module: `irsir_codec`

## Requirements
- R1: With `en` low, `ir_out` equals `uart_tx` and `uart_rx` equals `ir_in` in the same cycle.
- R2: After reset with `en` high, `ir_out` is 0 and `uart_rx` is 1; a bit of value 1 on `uart_tx` produces no pulse on `ir_out`.
- R3: In baud mode (`lp_mode`=0), a 0 on `uart_tx` sampled together with a `tick16` pulse that starts a bit raises `ir_out` in the next cycle; it stays high for exactly 3 tick intervals, and one pulse is made per 16 ticks while `uart_tx` stays 0.
- R4: In low-power mode (`lp_mode`=1) the transmit pulse starts the same way as in R3 and lasts between 2P+1 and 3P clock cycles, where P is the effective prescaler value.
- R5: A prescaler value of 0 acts as 1, so the low-power transmit pulse is exactly 3 cycles long.
- R6: The low-power clock ticks once every P system clock cycles.
- R7: `ir_in` passes through two flops before measurement; a low is accepted once it has spanned 2 unit ticks (unit tick = `tick16` in baud mode, low-power tick in low-power mode). A low shorter than one unit period never produces a zero on `uart_rx`; a low longer than two unit periods always does.
- R8: An accepted low drives `uart_rx` to 0 until the 16th `tick16` after acceptance, so with ticks every T cycles it stays low for between 15T+1 and 16T cycles and then returns to 1.
- R9: Deasserting `en` clears all transmit and receive state, so after re-enabling `ir_out` is 0 and `uart_rx` is 1 until new activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Codec enable; low selects pass-through |
| lp_mode | input | 1 | 0 = baud-timed pulses, 1 = low-power prescaled pulses |
| psc | input | PSC_W (8) | Low-power clock divisor; 0 treated as 1 |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| uart_tx | input | 1 | Serial transmit bit stream from the UART |
| ir_in | input | 1 | Asynchronous active-low pulse input from the transceiver |
| ir_out | output | 1 | Active-high pulse output to the transceiver |
| uart_rx | output | 1 | Recovered serial bit stream to the UART |

## Verification
A stuck or miscounted transmit phase counter shows at `ir_out` within one bit: the pulse has the wrong width or a second pulse appears before sixteen ticks have passed. A wrong receive filter count shows within one pulse as a glitch that reaches `uart_rx` or a long pulse that never does, and a wrong hold counter shows as a zero bit that is stretched or cut relative to sixteen ticks. State left over across a disable shows on the first cycle after re-enabling as a pulse or a zero that no input caused.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

    localparam int OVS            = 16;
    localparam int PH_W           = $clog2(OVS);
    localparam int TX_PULSE_TICKS = 3;
    localparam int LP_PULSE_UNITS = 3;
    localparam int LPC_W          = $clog2(LP_PULSE_UNITS + 1);
    localparam int RX_MIN_UNITS   = 2;
    localparam int LC_W           = $clog2(RX_MIN_UNITS + 1);

    typedef struct packed {
        logic             busy;
        logic             pulse;
        logic [PH_W-1:0]  ph;
        logic [LPC_W-1:0] lpc;
    } tx_state_t;

    typedef struct packed {
        logic            s1;
        logic            s2;
        logic [LC_W-1:0] low_cnt;
        logic            armed;
        logic            hold;
        logic [PH_W-1:0] hcnt;
    } rx_state_t;

    localparam rx_state_t RX_IDLE = '{s1: 1'b1, s2: 1'b1, low_cnt: '0,
                                      armed: 1'b1, hold: 1'b0, hcnt: '0};

endpackage

// File: rtl/irsir_lp_divider.sv
module irsir_lp_divider #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    output logic             lp_tick
);
    logic [PSC_W-1:0] cnt_d, cnt_q;
    logic [PSC_W-1:0] last;

    always_comb begin
        last    = (psc == '0) ? '0 : psc - 1'b1;
        lp_tick = (cnt_q >= last);
        cnt_d   = lp_tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/irsir_tx_enc.sv
module irsir_tx_enc
    import irsir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lp_mode,
    input  logic tick16,
    input  logic lp_tick,
    input  logic tx_bit,
    output logic pulse
);
    tx_state_t d, q;

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else if (tick16 && !q.busy) begin
            if (!tx_bit) begin
                d.busy  = 1'b1;
                d.pulse = 1'b1;
                d.ph    = PH_W'(1);
                d.lpc   = '0;
            end
        end else begin
            if (q.busy && tick16) begin
                if (q.ph == PH_W'(OVS - 1)) begin
                    d.busy = 1'b0;
                    d.ph   = '0;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
                if (!lp_mode && q.ph == PH_W'(TX_PULSE_TICKS))
                    d.pulse = 1'b0;
            end
            if (lp_mode && q.pulse && lp_tick) begin
                if (q.lpc == LPC_W'(LP_PULSE_UNITS - 1)) begin
                    d.pulse = 1'b0;
                    d.lpc   = '0;
                end else begin
                    d.lpc = q.lpc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse = q.pulse;
endmodule

// File: rtl/irsir_rx_dec.sv
module irsir_rx_dec
    import irsir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lp_mode,
    input  logic tick16,
    input  logic lp_tick,
    input  logic ir_line,
    output logic zero_hold
);
    rx_state_t d, q;
    logic      unit_tick;
    logic      accept;

    always_comb begin
        d         = q;
        d.s1      = ir_line;
        d.s2      = q.s1;
        unit_tick = lp_mode ? lp_tick : tick16;
        accept    = 1'b0;

        if (q.s2) begin
            d.low_cnt = '0;
            d.armed   = 1'b1;
        end else if (unit_tick && q.armed) begin
            if (q.low_cnt == LC_W'(RX_MIN_UNITS - 1)) begin
                accept    = 1'b1;
                d.armed   = 1'b0;
                d.low_cnt = '0;
            end else begin
                d.low_cnt = q.low_cnt + 1'b1;
            end
        end

        if (accept) begin
            d.hold = 1'b1;
            d.hcnt = '0;
        end else if (q.hold && tick16) begin
            if (q.hcnt == PH_W'(OVS - 1)) begin
                d.hold = 1'b0;
                d.hcnt = '0;
            end else begin
                d.hcnt = q.hcnt + 1'b1;
            end
        end

        if (!en) d = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_IDLE;
        else        q <= d;
    end

    assign zero_hold = q.hold;
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             lp_mode,
    input  logic [PSC_W-1:0] psc,
    input  logic             tick16,
    input  logic             uart_tx,
    input  logic             ir_in,
    output logic             ir_out,
    output logic             uart_rx
);
    logic lp_tick;
    logic tx_pulse;
    logic rx_zero;

    irsir_lp_divider #(.PSC_W(PSC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc     (psc),
        .lp_tick (lp_tick)
    );

    irsir_tx_enc u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .lp_mode (lp_mode),
        .tick16  (tick16),
        .lp_tick (lp_tick),
        .tx_bit  (uart_tx),
        .pulse   (tx_pulse)
    );

    irsir_rx_dec u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .lp_mode   (lp_mode),
        .tick16    (tick16),
        .lp_tick   (lp_tick),
        .ir_line   (ir_in),
        .zero_hold (rx_zero)
    );

    assign ir_out  = en ? tx_pulse : uart_tx;
    assign uart_rx = en ? ~rx_zero : ir_in;
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk #(
    parameter int PSC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             lp_mode,
    input logic [PSC_W-1:0] psc,
    input logic             tick16,
    input logic             uart_tx,
    input logic             ir_in,
    input logic             ir_out,
    input logic             uart_rx,
    input logic             lp_tick
);
    a_r3_rise_needs_zero_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $rose(ir_out)) |-> ($past(tick16) && !$past(uart_tx)));

    a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !lp_mode && !$past(lp_mode) && $fell(ir_out)) |-> $past(tick16));

    a_r7_rx_zero_needs_low_input: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $fell(uart_rx)) |-> !$past(ir_in, 3));

    a_r6_lp_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_tick && psc > 1) |=> (!lp_tick || !$stable(psc)));
endmodule

bind irsir_codec irsir_codec_chk #(.PSC_W(PSC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .lp_mode (lp_mode),
    .psc     (psc),
    .tick16  (tick16),
    .uart_tx (uart_tx),
    .ir_in   (ir_in),
    .ir_out  (ir_out),
    .uart_rx (uart_rx),
    .lp_tick (lp_tick)
);

// File: tb/irsir_codec_bench.sv
module irsir_codec_bench;
    logic       clk = 1'b0;
    logic       rst_n, en, lp_mode, uart_tx, ir_in;
    logic [7:0] psc;
    logic       auto_t = 1'b0, man_t = 1'b0, tick_auto = 1'b0;
    logic       tick16, ir_out, uart_rx;
    int         tdiv = 4;
    int         tcnt = 0;
    int         n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;
    assign tick16 = tick_auto ? auto_t : man_t;

    always @(negedge clk) begin
        auto_t = (tcnt == 0);
        tcnt   = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    end

    irsir_codec u_irsir_codec (
        .clk(clk), .rst_n(rst_n), .en(en), .lp_mode(lp_mode), .psc(psc),
        .tick16(tick16), .uart_tx(uart_tx), .ir_in(ir_in),
        .ir_out(ir_out), .uart_rx(uart_rx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one bit of 16 manual ticks spaced t cycles; returns high count and first sample
    task automatic send_bit(input logic b, input int t, output int hi, output logic first);
        hi = 0;
        first = 1'b0;
        uart_tx = b;
        for (int k = 0; k < 16 * t; k++) begin
            man_t = (k % t == 0);
            @(posedge clk);
            @(negedge clk);
            if (ir_out) hi++;
            if (k == 0) first = ir_out;
        end
        man_t = 1'b0;
    endtask

    // low pulse of l cycles on ir_in, returns count of low cycles on uart_rx
    task automatic rx_pulse(input int l, output int lows);
        lows = 0;
        ir_in = 1'b0;
        for (int k = 0; k < l; k++) begin
            @(negedge clk);
            if (!uart_rx) lows++;
        end
        ir_in = 1'b1;
        for (int k = 0; k < 20 * tdiv + 8; k++) begin
            @(negedge clk);
            if (!uart_rx) lows++;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int   hi, lows;
        logic first;
        rst_n = 1'b0; en = 1'b1; lp_mode = 1'b0; psc = 8'd3;
        uart_tx = 1'b1; ir_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ir_out == 1'b0, "R2 reset ir_out", ir_out, 0);
        chk(uart_rx == 1'b1, "R2 reset uart_rx", uart_rx, 1);

        // R1 bypass
        en = 1'b0;
        for (int v = 0; v < 4; v++) begin
            uart_tx = v[0]; ir_in = v[1];
            #1;
            chk(ir_out == uart_tx, "R1 bypass tx", ir_out, uart_tx);
            chk(uart_rx == ir_in, "R1 bypass rx", uart_rx, ir_in);
        end
        uart_tx = 1'b1; ir_in = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);

        // R2/R3 baud mode sweep over all 4-bit patterns
        tick_auto = 1'b0;
        for (int p = 0; p < 16; p++) begin
            for (int b = 0; b < 4; b++) begin
                send_bit(p[b], 4, hi, first);
                if (p[b]) begin
                    chk(hi == 0, "R2 one bit no pulse", hi, 0);
                end else begin
                    chk(hi == 12, "R3 pulse width 3 ticks", hi, 12);
                    chk(first == 1'b1, "R3 pulse starts next cycle", first, 1);
                end
            end
        end
        uart_tx = 1'b1;

        // R4/R5/R6 low-power transmit
        lp_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            int pe;
            psc = (i == 0) ? 8'd0 : (i == 1) ? 8'd1 : (i == 2) ? 8'd3 : 8'd5;
            pe = (psc == 0) ? 1 : psc;
            for (int b = 0; b < 3; b++) begin
                send_bit(1'b0, 8, hi, first);
                if (pe == 1)
                    chk(hi == 3, "R5 zero prescaler width", hi, 3);
                else
                    chk(hi >= 2 * pe + 1 && hi <= 3 * pe, "R4 R6 lp pulse width", hi, 3 * pe);
                chk(first == 1'b1, "R4 lp pulse start", first, 1);
            end
            send_bit(1'b1, 8, hi, first);
            chk(hi == 0, "R2 lp one bit", hi, 0);
        end
        uart_tx = 1'b1;

        // R7/R8 baud-mode receive
        lp_mode = 1'b0; tick_auto = 1'b1; tdiv = 4;
        repeat (8) @(negedge clk);
        for (int l = 1; l <= 20; l++) begin
            if (l < 4 || l > 8) begin
                rx_pulse(l, lows);
                if (l < 4) chk(lows == 0, "R7 glitch rejected", lows, 0);
                else chk(lows >= 61 && lows <= 64, "R7 R8 accepted zero length", lows, 64);
            end
        end

        // R7/R8 low-power receive, P = 5
        lp_mode = 1'b1; psc = 8'd5;
        for (int l = 1; l <= 22; l++) begin
            if (l < 5 || l > 10) begin
                rx_pulse(l, lows);
                if (l < 5) chk(lows == 0, "R7 lp glitch rejected", lows, 0);
                else chk(lows >= 61 && lows <= 64, "R7 R8 lp accepted zero length", lows, 64);
            end
        end

        // R9 disable clears receive state
        lp_mode = 1'b0;
        ir_in = 1'b0;
        repeat (12) @(negedge clk);
        ir_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(uart_rx == 1'b0, "R9 zero in progress", uart_rx, 0);
        en = 1'b0;
        @(negedge clk);
        chk(uart_rx == 1'b1, "R9 bypass rx", uart_rx, 1);
        en = 1'b1;
        @(negedge clk);
        chk(uart_rx == 1'b1, "R9 rx cleared", uart_rx, 1);
        lows = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (!uart_rx) lows++;
        end
        chk(lows == 0, "R9 rx stays idle", lows, 0);

        // R9 disable clears transmit state
        tick_auto = 1'b0;
        uart_tx = 1'b0; man_t = 1'b1;
        @(negedge clk);
        man_t = 1'b0;
        chk(ir_out == 1'b1, "R9 pulse in progress", ir_out, 1);
        en = 1'b0;
        @(negedge clk);
        uart_tx = 1'b1;
        en = 1'b1;
        #1;
        chk(ir_out == 1'b0, "R9 tx cleared", ir_out, 0);
        repeat (20) @(negedge clk);
        chk(ir_out == 1'b0, "R9 tx stays idle", ir_out, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule